// File: doc/BRIEF.md
# Sub-Window Integral Image Generator

The block builds the summed-area table and the summed-squares table for one fixed sub-window of 16 columns by 8 rows of 8-bit pixels. A host writes the pixels one per clock in raster order over a write port that has no wait states. Each pixel carries its linear address. The block keeps a running sum along the current row. It adds the value held for the same column one row above and stores the result. Once the last pixel is in, a downstream feature calculator reads any entry by address through a separate read port. Every read has a fixed latency of one cycle.

Each of the two results has its own lane, and the lanes are identical. The plain lane takes the pixel. The squared lane takes the pixel multiplied by itself. Each lane holds two 128 x 32 memories. The main memory keeps its only read port for external reads. A mirror memory receives every write a second time and supplies the value from the row above. A `done` flag marks a complete window. Writing address 0 begins a new window.

Top module: `win_integral_gen`

## Requirements
- R1: After reset, `done` is 0.
- R2: Pixel (x, y) is written at linear address a = x + 16*y, so x = a[3:0] and y = a[6:4]. Once a window is complete, `rd_ii` for address a equals the sum of every pixel at (x', y') with x' <= x and y' <= y.
- R3: Once a window is complete, `rd_sq` for address a equals the sum of the squares of the same pixels as in R2.
- R4: The running row sum starts again at every pixel with x = 0, so the entry at (0, y) is the column sum of column 0 up to row y, with nothing carried over from the end of the row before.
- R5: On row y = 0 nothing is added from a row above, so the entry at (x, 0) is the prefix sum of row 0 alone. This holds even when the memories still contain data from an earlier window.
- R6: `done` becomes 1 at the rising edge that follows the edge accepting the write to address 127, and not before.
- R7: `done` becomes 0 at the rising edge that follows the edge accepting a write to address 0.
- R8: A write to address 0 in the middle of a window starts a new window. A full window written after that gives correct results.
- R9: `rd_ii` and `rd_sq` show the data for `rd_addr` one rising edge after the address is presented, and they do not change before that edge.
- R10: With every pixel at 255, address 127 gives `rd_ii` = 32640 and `rd_sq` = 8323200, with no overflow.
- R11: Idle cycles (with `wr_en` low) inserted between pixel writes do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Pixel write strobe, one pixel per cycle |
| wr_addr | input | 7 | Linear pixel address x + 16*y |
| wr_pixel | input | 8 | Unsigned pixel value |
| rd_addr | input | 7 | Linear address of the entry to read |
| rd_ii | output | 32 | Integral image entry, one cycle after `rd_addr` |
| rd_sq | output | 32 | Integral squared entry, one cycle after `rd_addr` |
| done | output | 1 | High once a full window is stored |

## Verification
The hardest situation to reach is a first-row entry that must ignore stale data in the mirror memory. The bench sets it up by running windows back to back with different pixel content, including a window of all zeros written after a full-scale one. Any leak from the row above then shows in the row-0 entries. A second hard case is a restart partway through a window. Here the bench writes address 0 and fifty more pixels, then starts a fresh window with a different pattern and compares every entry. Timing of the pipeline is checked with windows written back to back and with an idle cycle after every pixel.

// File: rtl/iig_pkg.sv
package iig_pkg;
  localparam int DEF_COLS  = 16;
  localparam int DEF_ROWS  = 8;
  localparam int DEF_PIX_W = 8;
  localparam int DEF_ACC_W = 32;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/iig_ram.sv
module iig_ram #(
  parameter int A_W = 7,
  parameter int D_W = 32,
  localparam int DEPTH = 1 << A_W
) (
  input  logic           clk,
  input  logic           we,
  input  logic [A_W-1:0] waddr,
  input  logic [D_W-1:0] wdata,
  input  logic           re,
  input  logic [A_W-1:0] raddr,
  output logic [D_W-1:0] rdata
);
  logic [D_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iig_lane.sv
module iig_lane #(
  parameter int A_W = 7,
  parameter int X_W = 4,
  parameter int D_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_vld,
  input  logic [A_W-1:0] s_addr,
  input  logic [D_W-1:0] s_val,
  input  logic           pr_re,
  input  logic [A_W-1:0] pr_addr,
  input  logic [A_W-1:0] rd_addr,
  output logic [D_W-1:0] rd_data,
  output logic [D_W-1:0] wr_data
);
  logic [D_W-1:0] acc_q, acc_d;
  logic [D_W-1:0] prev_q;
  logic [D_W-1:0] row_sum;
  logic [X_W-1:0] col;
  logic           first_row;

  assign col       = s_addr[X_W-1:0];
  assign first_row = (s_addr[A_W-1:X_W] == '0);

  always_comb begin
    row_sum = ((col == '0) ? '0 : acc_q) + s_val;
    wr_data = row_sum + (first_row ? '0 : prev_q);
    acc_d   = s_vld ? row_sum : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  iig_ram #(.A_W(A_W), .D_W(D_W)) main_ram_i (
    .clk(clk), .we(s_vld), .waddr(s_addr), .wdata(wr_data),
    .re(1'b1), .raddr(rd_addr), .rdata(rd_data)
  );

  iig_ram #(.A_W(A_W), .D_W(D_W)) mirror_ram_i (
    .clk(clk), .we(s_vld), .waddr(s_addr), .wdata(wr_data),
    .re(pr_re), .raddr(pr_addr), .rdata(prev_q)
  );

  // R2: consecutive entries along a row never decrease
  p_row_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && col != '0 && $past(s_vld) && $past(s_addr) == s_addr - A_W'(1))
      |-> (wr_data >= $past(wr_data)));

  // R5: the window origin stores the bare input value
  p_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && s_addr == '0) |-> (wr_data == s_val));
endmodule

// File: rtl/win_integral_gen.sv
module win_integral_gen #(
  parameter int COLS  = iig_pkg::DEF_COLS,
  parameter int ROWS  = iig_pkg::DEF_ROWS,
  parameter int PIX_W = iig_pkg::DEF_PIX_W,
  parameter int ACC_W = iig_pkg::DEF_ACC_W,
  localparam int A_W  = $clog2(COLS * ROWS),
  localparam int X_W  = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [A_W-1:0]   wr_addr,
  input  logic [PIX_W-1:0] wr_pixel,
  input  logic [A_W-1:0]   rd_addr,
  output logic [ACC_W-1:0] rd_ii,
  output logic [ACC_W-1:0] rd_sq,
  output logic             done
);
  localparam int LANES = iig_pkg::NUM_LANES;
  localparam logic [A_W-1:0] LAST = A_W'(COLS * ROWS - 1);

  logic [1:0]         rs_q;
  logic               rst_int_n;
  logic               v1_q, v1_d;
  logic [A_W-1:0]     a1_q, a1_d;
  logic [PIX_W-1:0]   p1_q, p1_d;
  logic               done_q, done_d;
  logic [2*PIX_W-1:0] sq_w;
  logic [A_W-1:0]     pr_addr;
  logic [ACC_W-1:0]   lane_val [LANES];
  logic [ACC_W-1:0]   lane_rd  [LANES];
  logic [ACC_W-1:0]   lane_wd  [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    v1_d   = wr_en;
    a1_d   = wr_en ? wr_addr  : a1_q;
    p1_d   = wr_en ? wr_pixel : p1_q;
    done_d = done_q;
    if (v1_q && a1_q == LAST)    done_d = 1'b1;
    else if (v1_q && a1_q == '0) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      v1_q   <= 1'b0;
      a1_q   <= '0;
      p1_q   <= '0;
      done_q <= 1'b0;
    end else begin
      v1_q   <= v1_d;
      a1_q   <= a1_d;
      p1_q   <= p1_d;
      done_q <= done_d;
    end
  end

  assign sq_w        = p1_q * p1_q;
  assign pr_addr     = wr_addr - A_W'(COLS);
  assign lane_val[0] = ACC_W'(p1_q);
  assign lane_val[1] = ACC_W'(sq_w);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iig_lane #(.A_W(A_W), .X_W(X_W), .D_W(ACC_W)) lane_i (
      .clk(clk), .rst_n(rst_int_n),
      .s_vld(v1_q), .s_addr(a1_q), .s_val(lane_val[g]),
      .pr_re(wr_en), .pr_addr(pr_addr),
      .rd_addr(rd_addr), .rd_data(lane_rd[g]), .wr_data(lane_wd[g])
    );
  end

  assign rd_ii = lane_rd[0];
  assign rd_sq = lane_rd[1];
  assign done  = done_q;

  // R6: last pixel stored raises done
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (v1_q && a1_q == LAST) |=> done);

  // R7: origin pixel stored clears done
  p_done_clr_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (v1_q && a1_q == '0) |=> !done);

  // R3: sum of squares never falls below plain sum of integer pixels
  p_sq_dominates_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    v1_q |-> (lane_wd[1] >= lane_wd[0]));
endmodule

// File: tb/win_integral_gen_tb_top.sv
`timescale 1ns/1ps
module win_integral_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  wr_addr;
  logic [7:0]  wr_pixel;
  logic [6:0]  rd_addr;
  logic [31:0] rd_ii;
  logic [31:0] rd_sq;
  logic        done;

  int checks;
  int errors;
  bit finished;
  longint ref_ii [128];
  longint ref_sq [128];
  logic [7:0] pix [128];

  // {kind, seed, gap}: kind 0 = all 255, 1 = ramp, 2 = hash, 3 = all zero
  localparam logic [23:0] PATS [5] = '{
    24'h02_3c_00, 24'h00_00_01, 24'h01_00_00, 24'h03_00_00, 24'h02_a7_01
  };

  win_integral_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_pixel(wr_pixel), .rd_addr(rd_addr), .rd_ii(rd_ii),
    .rd_sq(rd_sq), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] pix_of(int kind, int seed, int a);
    case (kind)
      0:       return 8'd255;
      1:       return 8'(a * 2);
      2:       return 8'(a * 37 + seed * 3 + (a >> 3));
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(string req, longint act, longint exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic build_ref(int kind, int seed);
    for (int a = 0; a < 128; a++) pix[a] = pix_of(kind, seed, a);
    for (int a = 0; a < 128; a++) begin
      longint s = 0;
      longint q = 0;
      for (int yy = 0; yy <= a / 16; yy++)
        for (int xx = 0; xx <= a % 16; xx++) begin
          s += longint'(pix[xx + 16 * yy]);
          q += longint'(pix[xx + 16 * yy]) * longint'(pix[xx + 16 * yy]);
        end
      ref_ii[a] = s;
      ref_sq[a] = q;
    end
  endtask

  task automatic write_px(int a, logic [7:0] p);
    wr_en = 1'b1;
    wr_addr = 7'(a);
    wr_pixel = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_window(bit gap);
    for (int a = 0; a < 128; a++) begin
      write_px(a, pix[a]);
      if (gap) @(negedge clk);
    end
  endtask

  task automatic check_all(bit gap);
    for (int a = 0; a < 128; a++) begin
      string t;
      rd_addr = 7'(a);
      @(negedge clk);
      if (gap)            t = "R11";
      else if (a < 16)    t = "R5";
      else if (a % 16 == 0) t = "R4";
      else                t = "R2";
      chk(t, longint'(rd_ii), ref_ii[a]);
      chk(gap ? "R11" : "R3", longint'(rd_sq), ref_sq[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    finished = 0;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_pixel = '0;
    rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", longint'(done), 0);

    foreach (PATS[i]) begin
      build_ref(int'(PATS[i][23:16]), int'(PATS[i][15:8]));
      write_window(PATS[i][0]);
      if (i == 0) begin
        chk("R6", longint'(done), 0);
        @(negedge clk);
        chk("R6", longint'(done), 1);
      end else begin
        repeat (2) @(negedge clk);
      end
      check_all(PATS[i][0]);
      if (PATS[i][23:16] == 8'd0) begin
        chk("R10", ref_ii[127], 32640);
        chk("R10", ref_sq[127], 8323200);
        rd_addr = 7'd127;
        @(negedge clk);
        chk("R10", longint'(rd_ii), 32640);
        chk("R10", longint'(rd_sq), 8323200);
      end
    end

    // R7 clear timing, then R8 restart mid-window
    chk("R7", longint'(done), 1);
    write_px(0, 8'd9);
    chk("R7", longint'(done), 1);
    for (int a = 1; a < 51; a++) begin
      write_px(a, 8'(a + 100));
      if (a == 1) chk("R7", longint'(done), 0);
    end
    build_ref(2, 8'h51);
    write_window(1'b0);
    repeat (2) @(negedge clk);
    chk("R8", longint'(done), 1);
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a);
      @(negedge clk);
      chk("R8", longint'(rd_ii), ref_ii[a]);
      chk("R8", longint'(rd_sq), ref_sq[a]);
    end

    // R9 read latency
    rd_addr = 7'd127;
    @(negedge clk);
    chk("R9", longint'(rd_ii), ref_ii[127]);
    rd_addr = 7'd5;
    #1;
    chk("R9", longint'(rd_ii), ref_ii[127]);
    chk("R9", longint'(rd_sq), ref_sq[127]);
    @(negedge clk);
    chk("R9", longint'(rd_ii), ref_ii[5]);
    chk("R9", longint'(rd_sq), ref_sq[5]);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule